// File: doc/BRIEF.md
# PDM Capture Register and Interrupt Interface

This block is the software-facing side of a multi-channel PDM microphone capture controller. A host reaches it over a simple single-cycle bus made of valid, write, address and data. Through that bus the host sets up the channel enables, the burst (chunk) length and a free configuration word. It pops captured samples out of a receive holding register and controls interrupts through separate write-only set and clear registers.

Decimated samples arrive on a push port, each tagged with its channel index. They are queued in a small receive FIFO that sits behind the holding register. The block raises a DMA request level while enough samples are queued for one burst. It raises an interrupt line for any enabled status condition. Reading the status register and reading the holding register both have side effects, so every read on the bus counts as a consuming access.

Top module: `pdm_rx_regif`

## Requirements
- R1: After reset, the status word reads 0x02 (only the empty bit set), and the mode, configuration and mask registers read 0. `irq`, `dma_req` and `chan_en` are all 0.
- R2: Address 0x50 reads the VERSION parameter in bits [11:0] with zeros above. Writes to 0x50, 0x1C, 0x20 and 0x0C change nothing.
- R3: The mode register at 0x04 and the configuration register at 0x08 read back what was written. `chan_en` equals mode bits [3:0], and the chunk length is mode bits [31:28].
- R4: A push on `smp_valid` is stored only when the mode enable bit of its `smp_chan` is set. A push for a disabled channel is dropped.
- R5: Reading the holding register at 0x0C returns the oldest sample as {channel index in [31:24], 24-bit audio in [23:0]}, and removes it from the FIFO. Samples leave in arrival order.
- R6: The status register at 0x20 has these level bits: bit 0 means data ready, bit 1 means FIFO empty, bit 2 means FIFO full, and bit 3 means occupancy is at least the chunk length (a chunk field of 0 counts as 1). `dma_req` follows bit 3.
- R7: A stored push that arrives while the FIFO is full and no pop happens in the same cycle is lost. It sets sticky status bit 5 (overrun).
- R8: A holding-register read while the FIFO is empty returns 0 and sets sticky status bit 4 (underrun).
- R9: Bits 4 and 5 clear on a status read, and that read still returns them set. If a new event lands in the same cycle as the clearing read, the event wins.
- R10: A write to 0x14 sets each mask bit whose data bit is 1, and a write to 0x18 clears each such bit. Only bits [5:0] exist. The mask reads back at 0x1C.
- R11: `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R12: Writing 1 to bit 0 of address 0x00 returns the mode, configuration, mask, FIFO and sticky bits to their reset values. Reads of 0x00, 0x14 and 0x18 return 0.
- R13: An address whose two low bits are not zero, or an address outside the map, reads 0 and is ignored on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| smp_valid | input | 1 | Sample push strobe |
| smp_chan | input | CH_W | Channel index of the pushed sample |
| smp_data | input | 24 | Audio sample |
| chan_en | output | NCH | Channel enables from the mode register |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 1 | DMA request level (chunk reached) |

## Verification
The assertions assume that `bus_valid`, `bus_write` and `smp_valid` are never unknown after reset. They also assume that each bus access lasts exactly one cycle, so a read always consumes as soon as it is presented. The bench drives each access for a single cycle at the falling edge and leaves an idle cycle between accesses. It keeps `smp_chan` inside the channel range. The FIFO scoreboard predicts which pushes are kept, using the enables that the bench itself programmed, so the expected order never depends on design internals.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;
  localparam int SMP_W = 24;
  localparam int IRQ_W = 6;

  localparam int ST_RDY   = 0;
  localparam int ST_EMPTY = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_CHUNK = 3;
  localparam int ST_UDR   = 4;
  localparam int ST_OVR   = 5;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_CFG   = 8'h08;
  localparam logic [7:0] OFS_HOLD  = 8'h0C;
  localparam logic [7:0] OFS_IEN   = 8'h14;
  localparam logic [7:0] OFS_IDIS  = 8'h18;
  localparam logic [7:0] OFS_IMASK = 8'h1C;
  localparam logic [7:0] OFS_ISTAT = 8'h20;
  localparam logic [7:0] OFS_VER   = 8'h50;

  // burst length from the mode chunk field; zero behaves as one
  function automatic int chunk_len(input logic [3:0] fld);
    return (fld == 4'd0) ? 1 : int'(fld);
  endfunction
endpackage

// File: rtl/pdm_rx_fifo.sv
module pdm_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 26,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             ovr_evt
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_wr, do_rd;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (int'(count) == DEPTH);
  assign do_rd   = pop && !empty;
  assign do_wr   = push && (!full || do_rd);
  assign ovr_evt = push && full && !do_rd;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= nxt(wr_ptr);
      if (do_rd) rd_ptr <= nxt(rd_ptr);
      if (do_wr && !do_rd) count <= count + 1'b1;
      else if (do_rd && !do_wr) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R7
  AST_FILL_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && $past(empty)) |-> $past(push)); // R4
endmodule

// File: rtl/pdm_irq_ctrl.sv
module pdm_irq_ctrl
  import pdm_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic [3:0]       lvl,
  input  logic             udr_evt,
  input  logic             ovr_evt,
  input  logic             en_wr,
  input  logic             dis_wr,
  input  logic [IRQ_W-1:0] bits,
  input  logic             stat_rd,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  logic udr_q, ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      mask  <= '0;
      udr_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (en_wr)  mask <= mask | bits;
      if (dis_wr) mask <= mask & ~bits;
      udr_q <= udr_evt || (udr_q && !stat_rd);
      ovr_q <= ovr_evt || (ovr_q && !stat_rd);
    end
  end

  assign status = {ovr_q, udr_q, lvl};
  assign irq    = |(status & mask);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0)); // R11
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !srst) |=> ((mask & $past(bits)) == $past(bits))); // R10
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_wr && !srst) |=> ((mask & $past(bits)) == '0)); // R10
endmodule

// File: rtl/pdm_rx_regif.sv
module pdm_rx_regif
  import pdm_rx_pkg::*;
#(
  parameter int          NCH        = 4,
  parameter int          FIFO_DEPTH = 8,
  parameter int          ADDR_W     = 8,
  parameter logic [11:0] VERSION    = 12'h1A3,
  localparam int         CH_W       = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int         ENT_W      = CH_W + SMP_W,
  localparam int         CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              smp_valid,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic [SMP_W-1:0]  smp_data,
  output logic [NCH-1:0]    chan_en,
  output logic              irq,
  output logic              dma_req
);
  logic [31:0]      mode_q, cfg_q;
  logic             wr_acc, rd_acc, aligned;
  logic             srst, hold_rd, stat_rd, en_wr, dis_wr;
  logic             smp_ok, udr_evt, ovr_evt;
  logic [ENT_W-1:0] fifo_q;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_empty, fifo_full, chunk_hit;
  logic [IRQ_W-1:0] status, mask;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_acc  = bus_valid && bus_write && aligned;
  assign rd_acc  = bus_valid && !bus_write && aligned;
  assign srst    = wr_acc && hit(bus_addr, OFS_CTRL) && bus_wdata[0];
  assign en_wr   = wr_acc && hit(bus_addr, OFS_IEN);
  assign dis_wr  = wr_acc && hit(bus_addr, OFS_IDIS);
  assign hold_rd = rd_acc && hit(bus_addr, OFS_HOLD);
  assign stat_rd = rd_acc && hit(bus_addr, OFS_ISTAT);
  assign smp_ok  = smp_valid && mode_q[smp_chan];
  assign udr_evt = hold_rd && fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      mode_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_acc && hit(bus_addr, OFS_MODE)) mode_q <= bus_wdata;
      if (wr_acc && hit(bus_addr, OFS_CFG))  cfg_q  <= bus_wdata;
    end
  end

  pdm_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst),
    .push    (smp_ok),
    .wdata   ({smp_chan, smp_data}),
    .pop     (hold_rd),
    .rdata   (fifo_q),
    .count   (fifo_cnt),
    .empty   (fifo_empty),
    .full    (fifo_full),
    .ovr_evt (ovr_evt)
  );

  assign chunk_hit = int'(fifo_cnt) >= chunk_len(mode_q[31:28]);

  pdm_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst),
    .lvl     ({chunk_hit, fifo_full, fifo_empty, !fifo_empty}),
    .udr_evt (udr_evt),
    .ovr_evt (ovr_evt),
    .en_wr   (en_wr),
    .dis_wr  (dis_wr),
    .bits    (bus_wdata[IRQ_W-1:0]),
    .stat_rd (stat_rd),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      if (hit(bus_addr, OFS_MODE))  bus_rdata = mode_q;
      if (hit(bus_addr, OFS_CFG))   bus_rdata = cfg_q;
      if (hit(bus_addr, OFS_IMASK)) bus_rdata = 32'(mask);
      if (hit(bus_addr, OFS_ISTAT)) bus_rdata = 32'(status);
      if (hit(bus_addr, OFS_VER))   bus_rdata = 32'(VERSION);
      if (hit(bus_addr, OFS_HOLD) && !fifo_empty)
        bus_rdata = {{(8 - CH_W){1'b0}}, fifo_q};
    end
  end

  assign chan_en = mode_q[NCH-1:0];
  assign dma_req = chunk_hit;

  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ok && fifo_full && !hold_rd && !srst) |=> status[ST_OVR]); // R7
  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_UDR] && !stat_rd && !srst) |=> status[ST_UDR]); // R9
  AST_UDR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rd && fifo_empty && !srst) |=> status[ST_UDR]); // R8
  AST_DMA_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !fifo_empty); // R6
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (chan_en == '0 && mask == '0 && fifo_empty)); // R12
endmodule

// File: tb/tb_pdm_rx_regif.sv
`timescale 1ns/1ps
module tb_pdm_rx_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = '0;
  logic [23:0] smp_data = '0;
  logic [3:0]  chan_en;
  logic        irq, dma_req;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  logic [3:0]  en_model = '0;
  int          occ = 0;

  always #2 clk = ~clk;

  pdm_rx_regif dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  // driver: push a sample and predict whether it is kept
  task automatic push(input logic [1:0] ch, input logic [23:0] v);
    @(negedge clk);
    smp_valid = 1; smp_chan = ch; smp_data = v;
    @(negedge clk);
    smp_valid = 0;
    if (en_model[ch] && occ < 8) begin
      exp_q.push_back({6'b0, ch, v});
      occ++;
    end
  endtask

  // monitor: pop the holding register and compare with the scoreboard
  task automatic drain(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      rd(8'h0C, d);
      check("R5 holding order", d, exp_q.pop_front());
      occ--;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h20, d); check("R1 status", d, 32'h2);
    rd(8'h04, d); check("R1 mode", d, 0);
    rd(8'h1C, d); check("R1 mask", d, 0);
    check("R1 irq/dma/en", {26'b0, irq, dma_req, chan_en}, 0);
    // R2 version, read-only writes
    rd(8'h50, d); check("R2 version", d, 32'h1A3);
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, d); check("R2 ver write", d, 32'h1A3);
    wr(8'h1C, 32'h3F); rd(8'h1C, d); check("R2 mask ro", d, 0);
    // R3 mode/cfg
    wr(8'h08, 32'hA5A5_1234); rd(8'h08, d); check("R3 cfg", d, 32'hA5A5_1234);
    wr(8'h04, 32'h4000_0005); en_model = 4'h5;
    rd(8'h04, d); check("R3 mode", d, 32'h4000_0005);
    check("R3 chan_en", {28'b0, chan_en}, 32'h5);
    // R4 disabled channel dropped
    push(2'd1, 24'h111111);
    rd(8'h20, d); check("R4 drop", d, 32'h2);
    // R10 mask set/clear, R11 irq
    wr(8'h14, 32'h3F); rd(8'h1C, d); check("R10 set", d, 32'h3F);
    wr(8'h18, 32'h1B); rd(8'h1C, d); check("R10 clr", d, 32'h24);
    check("R11 irq idle", {31'b0, irq}, 0);
    rd(8'h14, d); check("R12 ien reads 0", d, 0);
    // R6 chunk of 4
    wr(8'h04, 32'h4000_000F); en_model = 4'hF;
    push(2'd0, 24'h000A01); push(2'd2, 24'h000A02); push(2'd3, 24'h000A03);
    check("R6 dma below chunk", {31'b0, dma_req}, 0);
    rd(8'h20, d); check("R6 status 3", d, 32'h1);
    push(2'd1, 24'h000A04);
    check("R6 dma at chunk", {31'b0, dma_req}, 1);
    // R7 fill and overflow
    push(2'd0, 24'h0B0001); push(2'd1, 24'h0B0002);
    push(2'd2, 24'h0B0003); push(2'd3, 24'h0B0004);
    check("R11 irq full", {31'b0, irq}, 1);
    push(2'd0, 24'hDEAD00);
    rd(8'h20, d); check("R7 overrun", d, 32'h2D);
    rd(8'h20, d); check("R9 cleared", d, 32'h0D);
    drain(8);
    // R8 underrun
    rd(8'h0C, d); check("R8 empty read", d, 0);
    check("R11 irq masked udr", {31'b0, irq}, 0);
    rd(8'h20, d); check("R8 udr set", d, 32'h12);
    rd(8'h20, d); check("R9 udr cleared", d, 32'h2);
    // chunk field zero behaves as one
    wr(8'h04, 32'h0000_0001); en_model = 4'h1;
    push(2'd0, 24'h123456);
    check("R6 chunk zero", {31'b0, dma_req}, 1);
    drain(1);
    // R13 unaligned/unmapped
    wr(8'h05, 32'h0000_000F); rd(8'h04, d); check("R13 unaligned wr", d, 32'h1);
    rd(8'h06, d); check("R13 unaligned rd", d, 0);
    rd(8'h10, d); check("R13 unmapped rd", d, 0);
    // R12 soft reset
    push(2'd0, 24'h777777);
    wr(8'h14, 32'h01);
    rd(8'h00, d); check("R12 ctrl reads 0", d, 0);
    wr(8'h00, 32'h1); en_model = 0; occ = 0; exp_q.delete();
    rd(8'h04, d); check("R12 mode", d, 0);
    rd(8'h08, d); check("R12 cfg", d, 0);
    rd(8'h1C, d); check("R12 mask", d, 0);
    rd(8'h20, d); check("R12 status", d, 32'h2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule